// File: doc/BRIEF.md
# Shared Buffer Priority Admission Encoder

This block tells upstream senders which traffic priorities may still be written into a shared packet buffer. It compares the buffer's current occupancy with one programmable threshold per priority. It registers the result as a thermometer-coded grant vector. A grant for any priority also grants every more urgent priority, that is, every priority with a lower number. A companion flag reports whether control packets may enter. Control packets are admissible whenever any priority is granted.

The grant is not refreshed every cycle. A free-running four-phase slot sequencer resamples the inputs once per slot. The grant register and the control flag then hold steady for the following four cycles. An update marker output is high in the first cycle of each slot, so a receiver can tell when fresh status is on the wire. The thresholds are not trusted to be ordered. Each priority's effective limit is clamped to at most the limit of the priority above it, so the output can never take a reserved code.

The sequencer has four states, visited in a fixed ring:
- PH_LOAD: the grant has just been loaded, and the update marker is high.
- PH_HOLD_A and PH_HOLD_B: hold cycles.
- PH_SAMPLE: the inputs present in this cycle are captured at its closing clock edge.

Its transitions are PH_LOAD→PH_HOLD_A, PH_HOLD_A→PH_HOLD_B, PH_HOLD_B→PH_SAMPLE and PH_SAMPLE→PH_LOAD. A synchronous reset forces PH_LOAD from any state.

Top module: `shm_prio_grant`

## Requirements
- R1: While `rst` is high, `grant_o` is 0, `ctrl_ok_o` is 0 and `upd_o` is 1; the sequencer sits in PH_LOAD.
- R2: Outside reset, `upd_o` is high for exactly one cycle in every four, with three low cycles between consecutive high cycles (ring PH_LOAD, PH_HOLD_A, PH_HOLD_B, PH_SAMPLE).
- R3: `grant_o` changes only on the clock edge that starts a cycle with `upd_o` high; in the other cycles it holds, whatever `occ_i` and `thr_i` do.
- R4: In the cycle with `upd_o` high, `grant_o[n]` (bit n = priority n, bit 0 the LSB) is 1 exactly when the `occ_i` seen in the preceding cycle is below L[n]. Here L[0] = T[0] and L[n] = min(T[n], L[n-1]), where T[n] = `thr_i[n*OCC_W +: OCC_W]`.
- R5: `grant_o` is always one of 4'b0000, 4'b0001, 4'b0011, 4'b0111 or 4'b1111; no other code is ever driven.
- R6: Occupancy equal to a limit does not grant that priority, and a threshold of 0 never grants. If thresholds are misordered (T[n] > T[n-1]), priority n is judged against the clamped limit.
- R7: `ctrl_ok_o` is 1 exactly when `grant_o` is nonzero, in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| occ_i | input | OCC_W | Current shared buffer occupancy |
| thr_i | input | NUM_PRIO*OCC_W | Per-priority thresholds, field n at bits n*OCC_W upward |
| grant_o | output | NUM_PRIO | Thermometer grant, bit n admits priority n |
| ctrl_ok_o | output | 1 | Control packets admissible |
| upd_o | output | 1 | High in the first cycle of each slot, when a fresh grant is visible |

## Verification
The bench builds the block with its defaults: NUM_PRIO = 4 and OCC_W = 8. With these values every one of the five legal codes can be reached with occupancies and thresholds between 0 and 255. The 8-bit range also allows a threshold of zero and an occupancy equal to a threshold. Deliberately misordered thresholds show that the clamping chain, not the comparator alone, decides the result. Junk inputs are driven during the hold cycles of some slots, to show that only the sampling cycle matters.

// File: rtl/prio_grant_pkg.sv
package prio_grant_pkg;

    // Four-cycle slot ring; PH_SAMPLE closes a slot by loading the grant
    typedef enum logic [1:0] {
        PH_LOAD   = 2'd0,
        PH_HOLD_A = 2'd1,
        PH_HOLD_B = 2'd2,
        PH_SAMPLE = 2'd3
    } slot_phase_e;

endpackage

// File: rtl/grant_slot_seq.sv
module grant_slot_seq
    import prio_grant_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic load_en_o,
    output logic fresh_o
);

    slot_phase_e phase_q;
    slot_phase_e phase_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_LOAD;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_LOAD:   phase_d = PH_HOLD_A;
            PH_HOLD_A: phase_d = PH_HOLD_B;
            PH_HOLD_B: phase_d = PH_SAMPLE;
            PH_SAMPLE: phase_d = PH_LOAD;
            default:   phase_d = PH_LOAD;
        endcase
    end

    always_comb begin
        load_en_o = 1'b0;
        fresh_o   = 1'b0;
        unique case (phase_q)
            PH_LOAD:   fresh_o   = 1'b1;
            PH_HOLD_A: ;
            PH_HOLD_B: ;
            PH_SAMPLE: load_en_o = 1'b1;
            default:   ;
        endcase
    end

    // R2
    wrap_order_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SAMPLE) |=> (phase_q == PH_LOAD));

    // R2
    hold_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HOLD_B) |=> (phase_q == PH_SAMPLE));

endmodule

// File: rtl/grant_limit_clamp.sv
module grant_limit_clamp #(
    parameter int NUM_PRIO = 4,
    parameter int OCC_W    = 8
) (
    input  logic [NUM_PRIO*OCC_W-1:0] thr_i,
    output logic [NUM_PRIO*OCC_W-1:0] lim_o
);

    // Running minimum from the most urgent priority downward
    for (genvar n = 0; n < NUM_PRIO; n++) begin : g_lim
        logic [OCC_W-1:0] own_thr;
        assign own_thr = thr_i[n*OCC_W +: OCC_W];
        if (n == 0) begin : g_head
            assign lim_o[n*OCC_W +: OCC_W] = own_thr;
        end else begin : g_link
            logic [OCC_W-1:0] up_lim;
            assign up_lim = lim_o[(n-1)*OCC_W +: OCC_W];
            assign lim_o[n*OCC_W +: OCC_W] = (own_thr < up_lim) ? own_thr : up_lim;
        end
    end

endmodule

// File: rtl/grant_compare.sv
module grant_compare #(
    parameter int NUM_PRIO = 4,
    parameter int OCC_W    = 8
) (
    input  logic [OCC_W-1:0]          occ_i,
    input  logic [NUM_PRIO*OCC_W-1:0] lim_i,
    output logic [NUM_PRIO-1:0]       grant_o
);

    for (genvar n = 0; n < NUM_PRIO; n++) begin : g_cmp
        assign grant_o[n] = (occ_i < lim_i[n*OCC_W +: OCC_W]);
    end

endmodule

// File: rtl/shm_prio_grant.sv
module shm_prio_grant #(
    parameter int NUM_PRIO = 4,
    parameter int OCC_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [OCC_W-1:0]          occ_i,
    input  logic [NUM_PRIO*OCC_W-1:0] thr_i,
    output logic [NUM_PRIO-1:0]       grant_o,
    output logic                      ctrl_ok_o,
    output logic                      upd_o
);

    localparam logic [NUM_PRIO-1:0] ONE_P = NUM_PRIO'(1);

    logic                      load_en;
    logic                      fresh;
    logic [NUM_PRIO*OCC_W-1:0] lim;
    logic [NUM_PRIO-1:0]       grant_next;
    logic [NUM_PRIO-1:0]       grant_q;
    logic                      ctrl_q;

    grant_slot_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .load_en_o (load_en),
        .fresh_o   (fresh)
    );

    grant_limit_clamp #(.NUM_PRIO(NUM_PRIO), .OCC_W(OCC_W)) u_clamp (
        .thr_i (thr_i),
        .lim_o (lim)
    );

    grant_compare #(.NUM_PRIO(NUM_PRIO), .OCC_W(OCC_W)) u_cmp (
        .occ_i   (occ_i),
        .lim_i   (lim),
        .grant_o (grant_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            ctrl_q  <= 1'b0;
        end else if (load_en) begin
            grant_q <= grant_next;
            ctrl_q  <= |grant_next;
        end
    end

    assign grant_o   = grant_q;
    assign ctrl_ok_o = ctrl_q;
    assign upd_o     = fresh;

    // R3
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_o |-> $stable(grant_o));

    // R5
    thermo_code_chk: assert property (@(posedge clk) disable iff (rst)
        ((grant_o & (grant_o + ONE_P)) == '0));

    // R7
    ctrl_match_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_ok_o == (grant_o != '0));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (grant_o == '0 && !ctrl_ok_o && upd_o));

endmodule

// File: tb/sim_shm_prio_grant.sv
module sim_shm_prio_grant;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int OW = 8;
    localparam int WATCHDOG_CYC = 20000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [OW-1:0]     occ = '0;
    logic [NP*OW-1:0]  thr = '0;
    logic [NP-1:0]     grant;
    logic              ctrl_ok;
    logic              upd;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [NP-1:0] exp_q [$];

    shm_prio_grant #(.NUM_PRIO(NP), .OCC_W(OW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .occ_i     (occ),
        .thr_i     (thr),
        .grant_o   (grant),
        .ctrl_ok_o (ctrl_ok),
        .upd_o     (upd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [NP-1:0] model(input logic [OW-1:0] o,
                                            input logic [OW-1:0] t0, input logic [OW-1:0] t1,
                                            input logic [OW-1:0] t2, input logic [OW-1:0] t3);
        logic [OW-1:0] t [NP];
        logic [OW-1:0] run;
        logic [NP-1:0] g;
        t[0] = t0; t[1] = t1; t[2] = t2; t[3] = t3;
        run = t[0];
        for (int n = 0; n < NP; n++) begin
            if (t[n] < run) run = t[n];
            g[n] = (o < run);
        end
        return g;
    endfunction

    // Driver: one call per slot; optional junk in the hold cycles
    task automatic drive_slot(input logic [OW-1:0] o,
                              input logic [OW-1:0] t0, input logic [OW-1:0] t1,
                              input logic [OW-1:0] t2, input logic [OW-1:0] t3,
                              input bit junk);
        do @(negedge clk); while (!upd);
        #1;
        if (junk) begin
            occ = ~o;
            thr = {~t3, ~t2, ~t1, ~t0};
        end
        repeat (3) @(negedge clk);
        #1;
        occ = o;
        thr = {t3, t2, t1, t0};
        exp_q.push_back(model(o, t0, t1, t2, t3));
    endtask

    // Monitor: per-cycle invariants and scoreboard compare at each update
    initial begin : monitor
        logic [NP-1:0] prev_g;
        int gap;
        bit seen;
        prev_g = '0;
        gap = 0;
        seen = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                gap++;
                check((grant & (grant + 4'd1)) == 4'd0, "R5 thermometer code", int'(grant), 0);
                check(ctrl_ok == (grant != 4'd0), "R7 control flag", int'(ctrl_ok), int'(grant != 4'd0));
                if (!upd) begin
                    check(grant == prev_g, "R3 hold between updates", int'(grant), int'(prev_g));
                end else begin
                    if (seen) check(gap == 4, "R2 update period", gap, 4);
                    seen = 1'b1;
                    gap = 0;
                    if (exp_q.size() > 0) begin
                        logic [NP-1:0] e;
                        e = exp_q.pop_front();
                        check(grant == e, "R4 R6 grant value", int'(grant), int'(e));
                    end
                end
                prev_g = grant;
            end
        end
    end

    initial begin : watchdog
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG_CYC, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset state
        check(grant == 4'd0, "R1 reset grant", int'(grant), 0);
        check(ctrl_ok == 1'b0, "R1 reset ctrl", int'(ctrl_ok), 0);
        check(upd == 1'b1, "R1 reset upd", int'(upd), 1);
        #1 rst = 1'b0;

        // R4: ordered thresholds sweep all five codes
        drive_slot(8'd0,   8'd200, 8'd150, 8'd100, 8'd50, 1'b0);
        drive_slot(8'd75,  8'd200, 8'd150, 8'd100, 8'd50, 1'b1);
        drive_slot(8'd120, 8'd200, 8'd150, 8'd100, 8'd50, 1'b0);
        drive_slot(8'd160, 8'd200, 8'd150, 8'd100, 8'd50, 1'b1);
        drive_slot(8'd220, 8'd200, 8'd150, 8'd100, 8'd50, 1'b0);
        drive_slot(8'd10,  8'd200, 8'd150, 8'd100, 8'd50, 1'b1);
        // R6: equality, zero threshold, misordered thresholds
        drive_slot(8'd100, 8'd200, 8'd150, 8'd100, 8'd50, 1'b0);
        drive_slot(8'd0,   8'd200, 8'd150, 8'd100, 8'd0,  1'b1);
        drive_slot(8'd0,   8'd0,   8'd150, 8'd100, 8'd50, 1'b0);
        drive_slot(8'd60,  8'd50,  8'd100, 8'd200, 8'd250, 1'b1);
        drive_slot(8'd40,  8'd50,  8'd100, 8'd200, 8'd250, 1'b0);
        drive_slot(8'd90,  8'd255, 8'd80,  8'd200, 8'd255, 1'b1);
        drive_slot(8'd254, 8'd255, 8'd255, 8'd255, 8'd255, 1'b0);
        drive_slot(8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 1'b0);

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule